// File: doc/BRIEF.md
# Interrupt Redirection Router with End-of-Interrupt Re-arm

This block routes a small set of interrupt request lines to a single local interrupt receiver. Every line owns a redirection entry that holds an 8-bit vector, a trigger mode (edge or level) and a mask. Software reaches all registers through an indirect pair: it first writes a register index, then reads or writes the data word that the index selects. The registers are an identification word with a writable 4-bit field, a constant version word, an arbitration word that shadows the identification field, and two words per redirection entry.

A rising edge on an unmasked edge entry records one request. An unmasked level entry requests while its line is high, as long as its remote-pending flag is clear. Granting a level delivery sets that flag, and an end-of-interrupt message that carries the entry's vector clears it. This gives coalescing of toggles before the end-of-interrupt, redelivery when the line is still high afterwards, and a delayed delivery when a held line is unmasked. Pending requests are offered one at a time on a valid/ready delivery port, lowest line first. Each delivery carries the vector and a flag that marks level mode.

The delivery port is driven by a two-state machine. In `ARB_IDLE` nothing is offered. The transition *claim* (any request present) loads the lowest requesting line and moves to `ARB_OFFER`. In `ARB_OFFER` the payload is held while `dlv_ready` is low. On acceptance, the transition *chain* loads the next lowest other request and stays in `ARB_OFFER`. The transition *drain* returns to `ARB_IDLE` when no other request is left.

Top module: `irq_router`

## Requirements
- R1: A data write to index 0x00 changes only bits 27:24 of the identification word, which reads back as the written value ANDed with 0x0F000000. The reset value is 0.
- R2: Index 0x01 always reads the version word {8'h00, N_LINES-1, 8'h00, 8'h20} (32'h00030020 with four lines), and writes to it have no effect.
- R3: Every write to index 0x00 loads the arbitration word at index 0x02 with the same readback value. Direct writes to index 0x02 leave it unchanged.
- R4: Line i's entry low word is at index 0x10+2i and its high word is at 0x11+2i. The low word has vector in bits 7:0, remote-pending in bit 14 (read-only), trigger in bit 15 (1 = level) and mask in bit 16. All other bits and the high word read 0. After reset every low word reads 32'h00010000.
- R5: An unmasked edge entry delivers exactly once per rising edge of its line, whatever the pulse width, with its vector and the level flag 0.
- R6: An unmasked level entry delivers once with the level flag 1 while its line is high, and its remote-pending bit then reads 1. An end-of-interrupt with its vector while the line is still high causes one more delivery.
- R7: Dropping and raising a level line before the end-of-interrupt adds no delivery.
- R8: A rising edge on a masked edge entry is discarded, and clearing the mask afterwards produces no delivery.
- R9: A level line held high while masked produces no delivery. Clearing the mask while it is still high produces exactly one delivery.
- R10: Requests pending together are all delivered, lowest line first, one per cycle while `dlv_ready` is high. While `dlv_ready` is low the offered vector and flag are held.
- R11: An end-of-interrupt whose vector differs from the entry's leaves its remote-pending bit set and causes no delivery. A matching one clears the bit.
- R12: A software write to an entry's low word in the same cycle as that entry's level delivery is accepted leaves remote-pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Load the register index |
| idx_wdata | input | 8 | New register index |
| dat_we | input | 1 | Write the data word at the current index |
| dat_wdata | input | 32 | Data word to write |
| dat_rdata | output | 32 | Data word at the current index |
| irq_in | input | N_LINES | Interrupt request lines |
| eoi_valid | input | 1 | End-of-interrupt message strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt message |
| dlv_valid | output | 1 | A delivery is offered |
| dlv_ready | input | 1 | The receiver accepts the offered delivery |
| dlv_vector | output | 8 | Vector of the offered delivery |
| dlv_level | output | 1 | 1 when the offered delivery comes from a level entry |

## Verification
Two events can land in the same cycle: a software rewrite of a redirection entry, and the acceptance of that entry's level delivery, which sets its remote-pending flag. The bench holds `dlv_ready` low until a level delivery is offered. It then raises `dlv_ready` and a data write to the entry's low word for the same clock edge. The result is judged by reading back bit 14 as 1 and by observing that no second delivery follows while the line stays high. Simultaneous edge requests are also provoked by pulsing all lines in one cycle under a stalled receiver. The bench then checks the order of the deliveries and that they arrive in consecutive cycles.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int VEC_W        = 8;
    localparam int IDX_W8       = 8;
    localparam int WORD_W       = 32;

    localparam logic [7:0] IDX_ID       = 8'h00;
    localparam logic [7:0] IDX_VER      = 8'h01;
    localparam logic [7:0] IDX_ARB      = 8'h02;
    localparam int         IDX_RTE_BASE = 16;

    localparam int RTE_RP_BIT   = 14;
    localparam int RTE_TRIG_BIT = 15;
    localparam int RTE_MASK_BIT = 16;
    localparam int ID_LSB       = 24;
    localparam int ID_W         = 4;

    localparam logic [7:0] VER_CODE = 8'h20;

    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OFFER = 1'b1
    } arb_state_e;

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_router_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      idx_we,
    input  logic [IDX_W8-1:0]         idx_wdata,
    input  logic                      dat_we,
    input  logic [WORD_W-1:0]         dat_wdata,
    output logic [WORD_W-1:0]         dat_rdata,
    input  logic [N-1:0]              rp,
    output logic [N-1:0][VEC_W-1:0]   vec,
    output logic [N-1:0]              trig,
    output logic [N-1:0]              mask
);

    localparam logic [7:0] MAX_ENTRY = 8'(N - 1);
    localparam logic [WORD_W-1:0] VER_WORD = {8'h00, MAX_ENTRY, 8'h00, VER_CODE};

    logic [IDX_W8-1:0] idx_q;
    logic [ID_W-1:0]   id_q;
    logic [ID_W-1:0]   arb_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_we) begin
            idx_q <= idx_wdata;
        end
    end

    // the identification field and its shadow are loaded by the same write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            arb_q <= '0;
        end else if (dat_we && idx_q == IDX_ID) begin
            id_q  <= dat_wdata[ID_LSB +: ID_W];
            arb_q <= dat_wdata[ID_LSB +: ID_W];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_entry
        localparam logic [7:0] LO_IDX = 8'(IDX_RTE_BASE + 2 * g);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec[g]  <= '0;
                trig[g] <= 1'b0;
                mask[g] <= 1'b1;
            end else if (dat_we && idx_q == LO_IDX) begin
                vec[g]  <= dat_wdata[VEC_W-1:0];
                trig[g] <= dat_wdata[RTE_TRIG_BIT];
                mask[g] <= dat_wdata[RTE_MASK_BIT];
            end
        end
    end

    always_comb begin
        dat_rdata = '0;
        unique case (idx_q)
            IDX_ID:  dat_rdata[ID_LSB +: ID_W] = id_q;
            IDX_VER: dat_rdata = VER_WORD;
            IDX_ARB: dat_rdata[ID_LSB +: ID_W] = arb_q;
            default: begin
                for (int i = 0; i < N; i++) begin
                    if (idx_q == 8'(IDX_RTE_BASE + 2 * i)) begin
                        dat_rdata[VEC_W-1:0]   = vec[i];
                        dat_rdata[RTE_RP_BIT]   = rp[i];
                        dat_rdata[RTE_TRIG_BIT] = trig[i];
                        dat_rdata[RTE_MASK_BIT] = mask[i];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/irq_line_ctl.sv
module irq_line_ctl
    import irq_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             trig,
    input  logic             mask,
    input  logic [VEC_W-1:0] vec,
    input  logic             grant,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    output logic             req,
    output logic             rp
);

    logic prev_q;
    logic edge_pend_q;
    logic rp_q;
    logic rise;

    assign rise = line_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= line_in;
        end
    end

    // a new edge in the grant cycle survives the grant of the previous one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_pend_q <= 1'b0;
        end else if (rise && !mask && !trig) begin
            edge_pend_q <= 1'b1;
        end else if (grant || trig) begin
            edge_pend_q <= 1'b0;
        end
    end

    // acceptance wins over any end-of-interrupt in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q <= 1'b0;
        end else if (grant && trig) begin
            rp_q <= 1'b1;
        end else if (eoi_valid && eoi_vector == vec && trig) begin
            rp_q <= 1'b0;
        end
    end

    assign req = trig ? (line_in & ~mask & ~rp_q) : edge_pend_q;
    assign rp  = rp_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_router_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            req,
    input  logic [N-1:0][VEC_W-1:0] vec,
    input  logic [N-1:0]            trig,
    input  logic                    dlv_ready,
    output logic [N-1:0]            grant,
    output logic                    dlv_valid,
    output logic [VEC_W-1:0]        dlv_vector,
    output logic                    dlv_level
);

    localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

    arb_state_e       state_q, state_d;
    logic [SEL_W-1:0] cur_q, sel;
    logic [VEC_W-1:0] vec_q;
    logic             lvl_q;
    logic             load;
    logic [N-1:0]     cur_oh;
    logic [N-1:0]     others;

    function automatic logic [SEL_W-1:0] pick_low(input logic [N-1:0] r);
        logic [SEL_W-1:0] p;
        p = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (r[k]) p = SEL_W'(k);
        end
        return p;
    endfunction

    assign cur_oh = {{(N-1){1'b0}}, 1'b1} << cur_q;
    assign others = req & ~cur_oh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        sel     = cur_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (|req) begin
                    state_d = ARB_OFFER;
                    load    = 1'b1;
                    sel     = pick_low(req);
                end
            end
            ARB_OFFER: begin
                if (dlv_ready) begin
                    if (|others) begin
                        load = 1'b1;
                        sel  = pick_low(others);
                    end else begin
                        state_d = ARB_IDLE;
                    end
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            vec_q <= '0;
            lvl_q <= 1'b0;
        end else if (load) begin
            cur_q <= sel;
            vec_q <= vec[sel];
            lvl_q <= trig[sel];
        end
    end

    always_comb begin
        dlv_valid  = (state_q == ARB_OFFER);
        dlv_vector = vec_q;
        dlv_level  = lvl_q;
        grant      = (dlv_valid && dlv_ready) ? cur_oh : '0;
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int N_LINES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_we,
    input  logic [7:0]         idx_wdata,
    input  logic               dat_we,
    input  logic [31:0]        dat_wdata,
    output logic [31:0]        dat_rdata,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               eoi_valid,
    input  logic [7:0]         eoi_vector,
    output logic               dlv_valid,
    input  logic               dlv_ready,
    output logic [7:0]         dlv_vector,
    output logic               dlv_level
);

    logic [N_LINES-1:0][VEC_W-1:0] vec_w;
    logic [N_LINES-1:0]            trig_w;
    logic [N_LINES-1:0]            mask_w;
    logic [N_LINES-1:0]            rp_w;
    logic [N_LINES-1:0]            req_w;
    logic [N_LINES-1:0]            grant_w;

    irq_regfile #(.N(N_LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_we    (idx_we),
        .idx_wdata (idx_wdata),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .dat_rdata (dat_rdata),
        .rp        (rp_w),
        .vec       (vec_w),
        .trig      (trig_w),
        .mask      (mask_w)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        irq_line_ctl u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_in    (irq_in[g]),
            .trig       (trig_w[g]),
            .mask       (mask_w[g]),
            .vec        (vec_w[g]),
            .grant      (grant_w[g]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .req        (req_w[g]),
            .rp         (rp_w[g])
        );
    end

    irq_arbiter #(.N(N_LINES)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req_w),
        .vec        (vec_w),
        .trig       (trig_w),
        .dlv_ready  (dlv_ready),
        .grant      (grant_w),
        .dlv_valid  (dlv_valid),
        .dlv_vector (dlv_vector),
        .dlv_level  (dlv_level)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int N = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dlv_valid,
    input logic               dlv_ready,
    input logic [7:0]         dlv_vector,
    input logic               dlv_level,
    input logic               eoi_valid,
    input logic [7:0]         eoi_vector,
    input logic [N-1:0]       grant,
    input logic [N-1:0]       rp,
    input logic [N-1:0][7:0]  vec
);

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_vector) && $stable(dlv_level)));

    p_single_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_grant_on_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> (dlv_valid && dlv_ready));

    for (genvar g = 0; g < N; g++) begin : g_line
        p_rp_from_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rp[g]) |-> $past(grant[g]));

        p_rp_from_eoi_r11: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rp[g]) |-> $past(eoi_valid && eoi_vector == vec[g]));
    end

endmodule

bind irq_router irq_router_chk #(.N(N_LINES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dlv_valid  (dlv_valid),
    .dlv_ready  (dlv_ready),
    .dlv_vector (dlv_vector),
    .dlv_level  (dlv_level),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .grant      (grant_w),
    .rp         (rp_w),
    .vec        (vec_w)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;

    localparam int NL = 4;
    localparam logic [31:0] VER_EXP = {8'h00, 8'(NL - 1), 8'h00, 8'h20};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_we = 1'b0;
    logic [7:0]  idx_wdata = '0;
    logic        dat_we = 1'b0;
    logic [31:0] dat_wdata = '0;
    logic [31:0] dat_rdata;
    logic [NL-1:0] irq_in = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        dlv_valid;
    logic        dlv_ready = 1'b1;
    logic [7:0]  dlv_vector;
    logic        dlv_level;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int dcount = 0;
    logic [7:0] log_vec [0:255];
    logic       log_lvl [0:255];
    int         log_cyc [0:255];

    always #5 clk = ~clk;

    irq_router #(.N_LINES(NL)) i_irq_router (
        .clk(clk), .rst_n(rst_n),
        .idx_we(idx_we), .idx_wdata(idx_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .irq_in(irq_in),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
        .dlv_vector(dlv_vector), .dlv_level(dlv_level)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && dlv_valid && dlv_ready) begin
            log_vec[dcount[7:0]] <= dlv_vector;
            log_lvl[dcount[7:0]] <= dlv_level;
            log_cyc[dcount[7:0]] <= cyc;
            dcount <= dcount + 1;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_idx(input logic [7:0] idx);
        @(negedge clk); idx_we = 1'b1; idx_wdata = idx;
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] idx, input logic [31:0] d);
        set_idx(idx);
        dat_we = 1'b1; dat_wdata = d;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] idx, output logic [31:0] d);
        set_idx(idx);
        d = dat_rdata;
    endtask

    function automatic logic [31:0] entry(input logic [7:0] v, input bit lvl, input bit msk);
        return (32'(msk) << 16) | (32'(lvl) << 15) | 32'(v);
    endfunction

    function automatic logic [7:0] lo_idx(input int line);
        return 8'(16 + 2 * line);
    endfunction

    task automatic cfg(input int line, input logic [7:0] v, input bit lvl, input bit msk);
        wr_reg(lo_idx(line), entry(v, lvl, msk));
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        int base;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R4 / R1 / R2 / R3: reset contents
        rd_reg(8'h00, rd); chk(rd == 32'h0, "R1 id reset", rd, 32'h0);
        rd_reg(8'h01, rd); chk(rd == VER_EXP, "R2 version", rd, VER_EXP);
        rd_reg(8'h02, rd); chk(rd == 32'h0, "R3 arb reset", rd, 32'h0);
        for (int i = 0; i < NL; i++) begin
            rd_reg(lo_idx(i), rd);
            chk(rd == 32'h00010000, "R4 entry low reset", rd, 32'h00010000);
            rd_reg(lo_idx(i) + 8'd1, rd);
            chk(rd == 32'h0, "R4 entry high word", rd, 32'h0);
        end
        chk(dlv_valid == 1'b0, "R4 no delivery after reset", 32'(dlv_valid), 32'h0);

        // R1 / R3: writable field and its shadow
        wr_reg(8'h00, 32'hFFFFFFFF);
        rd_reg(8'h00, rd); chk(rd == 32'h0F000000, "R1 id all ones", rd, 32'h0F000000);
        wr_reg(8'h00, 32'h0A5A5A5A);
        rd_reg(8'h00, rd); chk(rd == 32'h0A000000, "R1 id pattern", rd, 32'h0A000000);
        rd_reg(8'h02, rd); chk(rd == 32'h0A000000, "R3 arb follows id", rd, 32'h0A000000);
        wr_reg(8'h02, 32'h0);
        rd_reg(8'h02, rd); chk(rd == 32'h0A000000, "R3 arb direct write ignored", rd, 32'h0A000000);
        wr_reg(8'h01, ~VER_EXP);
        rd_reg(8'h01, rd); chk(rd == VER_EXP, "R2 version write ignored", rd, VER_EXP);

        // R5: edge entries, every line, short and long pulses
        for (int i = 0; i < NL; i++) begin
            cfg(i, 8'(8'h40 + i), 1'b0, 1'b0);
            for (int w = 1; w <= 4; w += 3) begin
                base = dcount;
                @(negedge clk); irq_in[i] = 1'b1;
                tick(w);
                irq_in[i] = 1'b0;
                tick(6);
                chk(dcount == base + 1, "R5 edge count", 32'(dcount - base), 32'd1);
                chk(log_vec[base[7:0]] == 8'(8'h40 + i) && log_lvl[base[7:0]] == 1'b0,
                    "R5 edge vector/flag", {23'h0, log_lvl[base[7:0]], log_vec[base[7:0]]}, 32'(8'h40 + i));
            end
            cfg(i, 8'(8'h40 + i), 1'b0, 1'b1);
        end

        // R6 / R11: level entries, every line
        for (int i = 0; i < NL; i++) begin
            logic [7:0] v;
            v = 8'(8'h80 + i);
            cfg(i, v, 1'b1, 1'b0);
            base = dcount;
            @(negedge clk); irq_in[i] = 1'b1;
            tick(6);
            chk(dcount == base + 1, "R6 level first delivery", 32'(dcount - base), 32'd1);
            chk(log_vec[base[7:0]] == v && log_lvl[base[7:0]] == 1'b1,
                "R6 level vector/flag", {23'h0, log_lvl[base[7:0]], log_vec[base[7:0]]}, {23'h0, 1'b1, v});
            rd_reg(lo_idx(i), rd);
            chk(rd == entry(v, 1'b1, 1'b0) + 32'h4000, "R6 remote-pending set", rd, entry(v, 1'b1, 1'b0) + 32'h4000);
            tick(6);
            chk(dcount == base + 1, "R6 no repeat before eoi", 32'(dcount - base), 32'd1);
            send_eoi(v ^ 8'h01);
            tick(6);
            chk(dcount == base + 1, "R11 mismatched eoi ignored", 32'(dcount - base), 32'd1);
            rd_reg(lo_idx(i), rd);
            chk(rd[14] == 1'b1, "R11 pending kept on mismatch", 32'(rd[14]), 32'd1);
            send_eoi(v);
            tick(6);
            chk(dcount == base + 2, "R6 redelivery after eoi", 32'(dcount - base), 32'd2);
            @(negedge clk); irq_in[i] = 1'b0;
            send_eoi(v);
            tick(4);
            rd_reg(lo_idx(i), rd);
            chk(rd[14] == 1'b0, "R11 matching eoi clears pending", 32'(rd[14]), 32'd0);
            chk(dcount == base + 2, "R11 no delivery after low line eoi", 32'(dcount - base), 32'd2);
            cfg(i, v, 1'b1, 1'b1);
        end

        // R7: coalescing on line 1
        cfg(1, 8'h91, 1'b1, 1'b0);
        base = dcount;
        @(negedge clk); irq_in[1] = 1'b1;
        tick(6);
        irq_in[1] = 1'b0; tick(2);
        irq_in[1] = 1'b1; tick(2);
        irq_in[1] = 1'b0; tick(2);
        send_eoi(8'h91);
        tick(6);
        chk(dcount == base + 1, "R7 toggles coalesced", 32'(dcount - base), 32'd1);
        cfg(1, 8'h91, 1'b1, 1'b1);

        // R8: masked edge discarded on line 3
        cfg(3, 8'h63, 1'b0, 1'b1);
        base = dcount;
        @(negedge clk); irq_in[3] = 1'b1;
        tick(2); irq_in[3] = 1'b0;
        tick(4);
        cfg(3, 8'h63, 1'b0, 1'b0);
        tick(6);
        chk(dcount == base, "R8 masked edge discarded", 32'(dcount - base), 32'd0);
        @(negedge clk); irq_in[3] = 1'b1;
        tick(1); irq_in[3] = 1'b0;
        tick(6);
        chk(dcount == base + 1, "R8 later edge delivered", 32'(dcount - base), 32'd1);
        cfg(3, 8'h63, 1'b0, 1'b1);

        // R9: masked level line 2, delivered on unmask
        cfg(2, 8'h72, 1'b1, 1'b1);
        base = dcount;
        @(negedge clk); irq_in[2] = 1'b1;
        tick(10);
        chk(dcount == base, "R9 masked level silent", 32'(dcount - base), 32'd0);
        cfg(2, 8'h72, 1'b1, 1'b0);
        tick(6);
        chk(dcount == base + 1 && log_vec[base[7:0]] == 8'h72, "R9 unmask delivers once",
            32'(dcount - base), 32'd1);
        @(negedge clk); irq_in[2] = 1'b0;
        send_eoi(8'h72);
        cfg(2, 8'h72, 1'b1, 1'b1);

        // R10: all lines at once under a stalled receiver
        for (int i = 0; i < NL; i++) cfg(i, 8'(8'h50 + i), 1'b0, 1'b0);
        base = dcount;
        @(negedge clk); dlv_ready = 1'b0; irq_in = '1;
        @(negedge clk); irq_in = '0;
        tick(5);
        chk(dlv_valid == 1'b1 && dlv_vector == 8'h50, "R10 stalled offer holds lowest line",
            {23'h0, dlv_valid, dlv_vector}, {23'h0, 1'b1, 8'h50});
        chk(dcount == base, "R10 nothing accepted while stalled", 32'(dcount - base), 32'd0);
        dlv_ready = 1'b1;
        tick(8);
        chk(dcount == base + NL, "R10 all delivered", 32'(dcount - base), 32'(NL));
        for (int k = 0; k < NL; k++) begin
            chk(log_vec[8'(base + k)] == 8'(8'h50 + k), "R10 lowest line first",
                32'(log_vec[8'(base + k)]), 32'(8'h50 + k));
        end
        for (int k = 1; k < NL; k++) begin
            chk(log_cyc[8'(base + k)] - log_cyc[8'(base + k - 1)] == 1, "R10 one per cycle",
                32'(log_cyc[8'(base + k)] - log_cyc[8'(base + k - 1)]), 32'd1);
        end
        for (int i = 0; i < NL; i++) cfg(i, 8'(8'h50 + i), 1'b0, 1'b1);

        // R12: entry write in the acceptance cycle
        cfg(2, 8'h92, 1'b1, 1'b0);
        set_idx(lo_idx(2));
        base = dcount;
        @(negedge clk); dlv_ready = 1'b0; irq_in[2] = 1'b1;
        for (int t = 0; t < 20 && !dlv_valid; t++) @(negedge clk);
        dlv_ready = 1'b1; dat_we = 1'b1; dat_wdata = entry(8'h92, 1'b1, 1'b0);
        @(negedge clk); dat_we = 1'b0;
        tick(2);
        rd_reg(lo_idx(2), rd);
        chk(rd == entry(8'h92, 1'b1, 1'b0) + 32'h4000, "R12 pending survives write", rd,
            entry(8'h92, 1'b1, 1'b0) + 32'h4000);
        tick(6);
        chk(dcount == base + 1, "R12 single delivery", 32'(dcount - base), 32'd1);
        @(negedge clk); irq_in[2] = 1'b0;
        send_eoi(8'h92);
        tick(3);

        summary();
    end

endmodule